// File: doc/BRIEF.md
# Endian-Adapting Bus Data Path

This block joins a 32-bit little-endian peripheral bus (bit 0 is the least significant bit) to a 32-bit big-endian processor data bus (bit 0 is the most significant bit). Read data travels from the peripheral bus to the processor, and write data travels the other way. Each byte keeps its lane on both sides. Only the bit numbering inside a byte changes, so that the most significant bit of a byte stays the most significant bit after the crossing.

On top of that fixed lane mapping, the processor can ask for a byte reversal that depends on the access size. This reversal plays the role of the processor's byte-reversing loads and stores, or of a page marked little-endian. The reversal is taken from the size of the current transaction. It reverses the byte order inside every aligned group of that size, and the byte enables travel with their bytes. A size or alignment the block cannot honour raises an error flag. In that case the data keeps the plain lane mapping and every enable is cleared.

The data path is combinational. A parameter can add one output register stage.

Top module: `endian_bridge`

## Requirements
- R1: With reversal off, processor byte lane n (big-endian bits 8n..8n+7) carries peripheral byte lane n (bits 8n+7..8n) on reads. Peripheral bit 8n+7 lands on big-endian bit 8n, and peripheral bit 8n lands on big-endian bit 8n+7.
- R2: Writes use the same lane-preserving, bit-renumbering map in the opposite direction.
- R3: The size code `acc_size` takes the values 0 (1 byte), 1 (2 bytes) and 2 (4 bytes); code 3 is reserved. A 1-byte access with reversal on passes every lane straight through.
- R4: A 2-byte access with reversal on swaps the two lanes inside each aligned halfword, on reads and writes alike. With lanes 0..3 holding DD,CC,BB,AA, the processor sees CC,DD,AA,BB.
- R5: A 4-byte access with reversal on maps lane 3 to lane 0, lane 2 to lane 1, lane 1 to lane 2 and lane 0 to lane 3. A peripheral word 0xAABBCCDD therefore reads as 0xAABBCCDD, with big-endian bit 0 as its MSB.
- R6: On writes, the reversal depends on size, address and enable in exactly the same way as on reads.
- R7: An access raises `align_err` and applies no reversal when any of these holds: a 2-byte access has `acc_addr[0]`=1, a 4-byte access has a nonzero `acc_addr`, or the size code is 3. Data then keeps the R1/R2 map and `bus_ben` is all zero.
- R8: When there is no error, `bus_ben[n]` equals the processor enable of the lane whose data byte is moved into peripheral lane n. With reversal off, this is `cpu_ben[n]`.
- R9: With `OUT_REG`=0, outputs follow the inputs in the same cycle. With `OUT_REG`=1, every output shows the result of the inputs exactly one clock later, and reset clears the registered outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| acc_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| acc_addr | input | 2 | Low byte-address bits of the access |
| rev_en | input | 1 | Enable the size-dependent byte reversal |
| bus_rdata | input | 32 | Read data from the little-endian bus, `[31:0]` |
| cpu_wdata | input | 32 | Write data from the processor, numbered `[0:31]` |
| cpu_ben | input | 4 | Processor byte enables, `[0:3]`, entry n for lane n |
| cpu_rdata | output | 32 | Read data to the processor, numbered `[0:31]` |
| bus_wdata | output | 32 | Write data to the little-endian bus, `[31:0]` |
| bus_ben | output | 4 | Peripheral byte enables, `[3:0]`, bit n for lane n |
| align_err | output | 1 | Unsupported size or misaligned access |

## Verification
The hardest case to provoke is an unaddressed halfword under a reversed 2-byte access. Its data and enables still move, but a test that only looks at the addressed lanes would never notice them. The stimulus therefore drives distinct bytes and asymmetric enable patterns into all four lanes, and compares every lane for both halfword addresses. It also walks every combination of size code, address and reversal enable with changing data. In each cycle the registered copy is checked twice: just before the clock edge it must still show the previous result, and just after the edge it must show the new one.

// File: rtl/endian_pkg.sv
package endian_pkg;

    localparam int unsigned BYTE_W = 8;

    // Mirror the bit order of one byte (MSB <-> LSB).
    function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/endian_ctrl.sv
module endian_ctrl #(
    parameter  int unsigned LANES = 4,
    localparam int unsigned AW    = $clog2(LANES),
    localparam int unsigned SZ_W  = $clog2(AW + 1)
) (
    input  logic [SZ_W-1:0] size_i,
    input  logic [AW-1:0]   addr_i,
    input  logic            rev_i,
    output logic [AW-1:0]   lane_xor_o,
    output logic            err_o
);

    logic [AW-1:0] grp_mask;

    // A size code s covers 2**s lanes; the low s address bits must be zero.
    always_comb begin
        for (int i = 0; i < int'(AW); i++) begin
            grp_mask[i] = (int'(size_i) > i);
        end
        err_o      = (int'(size_i) > int'(AW)) || ((addr_i & grp_mask) != '0);
        lane_xor_o = (rev_i && !err_o) ? grp_mask : '0;
    end

endmodule

// File: rtl/endian_lane_map.sv
module endian_lane_map #(
    parameter  int unsigned LANES = 4,
    parameter  int unsigned BW    = 8,
    parameter  bit          FLIP  = 1'b1,
    localparam int unsigned AW    = $clog2(LANES),
    localparam int unsigned W     = LANES * BW
) (
    input  logic [W-1:0]  src_i,
    input  logic [AW-1:0] lane_xor_i,
    output logic [W-1:0]  dst_o
);

    // Destination lane j takes source lane (j xor lane_xor). The bit order
    // inside a lane is mirrored when the two sides number bits oppositely.
    always_comb begin
        dst_o = '0;
        for (int j = 0; j < int'(LANES); j++) begin
            for (int k = 0; k < int'(BW); k++) begin
                if (FLIP) begin
                    dst_o[j*BW + k] = src_i[(j ^ int'(lane_xor_i))*BW + (BW - 1 - k)];
                end else begin
                    dst_o[j*BW + k] = src_i[(j ^ int'(lane_xor_i))*BW + k];
                end
            end
        end
    end

endmodule

// File: rtl/endian_bridge.sv
module endian_bridge #(
    parameter  int unsigned LANES   = 4,
    parameter  bit          OUT_REG = 1'b0,
    localparam int unsigned BW      = endian_pkg::BYTE_W,
    localparam int unsigned W       = LANES * BW,
    localparam int unsigned AW      = $clog2(LANES),
    localparam int unsigned SZ_W    = $clog2(AW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SZ_W-1:0] acc_size,
    input  logic [AW-1:0]   acc_addr,
    input  logic            rev_en,
    input  logic [W-1:0]    bus_rdata,
    input  logic [0:W-1]    cpu_wdata,
    input  logic [0:LANES-1] cpu_ben,
    output logic [0:W-1]    cpu_rdata,
    output logic [W-1:0]    bus_wdata,
    output logic [LANES-1:0] bus_ben,
    output logic            align_err
);

    typedef struct packed {
        logic [W-1:0]     rdata;
        logic [W-1:0]     wdata;
        logic [LANES-1:0] ben;
        logic             err;
    } out_t;

    out_t             out_d, out_q;
    logic [AW-1:0]    lane_xor;
    logic             acc_err;
    logic [W-1:0]     rd_be;
    logic [W-1:0]     wr_be;
    logic [W-1:0]     wr_le;
    logic [LANES-1:0] ben_in;
    logic [LANES-1:0] ben_mapped;

    // Plain lane-preserving map, used as the reference for the checks.
    function automatic logic [W-1:0] lanes_fixed(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int j = 0; j < int'(LANES); j++) begin
            r[j*BW +: BW] = endian_pkg::flip_byte(v[j*BW +: BW]);
        end
        return r;
    endfunction

    // Internal vectors are indexed by the bus's own bit numbers.
    for (genvar i = 0; i < int'(W); i++) begin : g_bits
        assign wr_be[i]     = cpu_wdata[i];
        assign cpu_rdata[i] = out_q.rdata[i];
    end
    for (genvar n = 0; n < int'(LANES); n++) begin : g_lanes
        assign ben_in[n] = cpu_ben[n];
    end

    endian_ctrl #(.LANES(LANES)) u_ctrl (
        .size_i     (acc_size),
        .addr_i     (acc_addr),
        .rev_i      (rev_en),
        .lane_xor_o (lane_xor),
        .err_o      (acc_err)
    );

    endian_lane_map #(.LANES(LANES), .BW(BW), .FLIP(1'b1)) u_rd_map (
        .src_i      (bus_rdata),
        .lane_xor_i (lane_xor),
        .dst_o      (rd_be)
    );

    endian_lane_map #(.LANES(LANES), .BW(BW), .FLIP(1'b1)) u_wr_map (
        .src_i      (wr_be),
        .lane_xor_i (lane_xor),
        .dst_o      (wr_le)
    );

    endian_lane_map #(.LANES(LANES), .BW(1), .FLIP(1'b0)) u_ben_map (
        .src_i      (ben_in),
        .lane_xor_i (lane_xor),
        .dst_o      (ben_mapped)
    );

    always_comb begin
        out_d.rdata = rd_be;
        out_d.wdata = wr_le;
        out_d.ben   = acc_err ? '0 : ben_mapped;
        out_d.err   = acc_err;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end

        // R9
        reg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (out_q == $past(out_d)));
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign bus_wdata = out_q.wdata;
    assign bus_ben   = out_q.ben;
    assign align_err = out_q.err;

    // R1
    lane_fix_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rev_en || acc_size == '0) |-> (rd_be == lanes_fixed(bus_rdata)));

    // R2
    lane_fix_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rev_en || acc_size == '0) |-> (wr_le == lanes_fixed(wr_be)));

    // R7
    misalign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (rd_be == lanes_fixed(bus_rdata) && wr_le == lanes_fixed(wr_be)));

    // R8
    ben_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_err |-> ($countones(out_d.ben) == $countones(ben_in)));

endmodule

// File: tb/test_endian_bridge.sv
`timescale 1ns/1ps
module test_endian_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_addr = '0;
    logic        rev_en = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_ben = '0;

    logic [31:0] c_rdata, r_rdata;
    logic [31:0] c_wdata, r_wdata;
    logic [3:0]  c_ben, r_ben;
    logic        c_err, r_err;

    int total = 0;
    int bad = 0;
    logic [31:0] p_rd = '0, p_wd = '0;
    logic [3:0]  p_be = '0;
    logic        p_er = 1'b0;

    always #4 clk = ~clk;

    endian_bridge #(.OUT_REG(1'b0)) i_endian_bridge (
        .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .acc_addr(acc_addr),
        .rev_en(rev_en), .bus_rdata(bus_rdata), .cpu_wdata(cpu_wdata),
        .cpu_ben(cpu_ben), .cpu_rdata(c_rdata), .bus_wdata(c_wdata),
        .bus_ben(c_ben), .align_err(c_err));

    endian_bridge #(.OUT_REG(1'b1)) i_endian_bridge_reg (
        .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .acc_addr(acc_addr),
        .rev_en(rev_en), .bus_rdata(bus_rdata), .cpu_wdata(cpu_wdata),
        .cpu_ben(cpu_ben), .cpu_rdata(r_rdata), .bus_wdata(r_wdata),
        .bus_ben(r_ben), .align_err(r_err));

    typedef struct packed {
        logic [1:0]  sz;
        logic [1:0]  ad;
        logic        rv;
        logic [31:0] rd;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [31:0] xrd;
        logic [31:0] xwd;
        logic [3:0]  xbe;
        logic        xer;
    } vec_t;

    // cpu_wdata/cpu_rdata values are written with big-endian bit 0 as MSB.
    localparam vec_t VECS [8] = '{
        '{2'd2, 2'd0, 1'b0, 32'hAABBCCDD, 32'h11223344, 4'b1010, 32'hDDCCBBAA, 32'h44332211, 4'b0101, 1'b0}, // R1 R2 R8
        '{2'd2, 2'd0, 1'b1, 32'hAABBCCDD, 32'h11223344, 4'b1000, 32'hAABBCCDD, 32'h11223344, 4'b1000, 1'b0}, // R5 R6 R8
        '{2'd1, 2'd0, 1'b1, 32'hAABBCCDD, 32'h11223344, 4'b1100, 32'hCCDDAABB, 32'h33441122, 4'b0011, 1'b0}, // R4 R6
        '{2'd1, 2'd2, 1'b1, 32'hAABBCCDD, 32'h11223344, 4'b0010, 32'hCCDDAABB, 32'h33441122, 4'b1000, 1'b0}, // R4 R8
        '{2'd0, 2'd1, 1'b1, 32'hAABBCCDD, 32'h11223344, 4'b0100, 32'hDDCCBBAA, 32'h44332211, 4'b0010, 1'b0}, // R3
        '{2'd1, 2'd1, 1'b1, 32'hAABBCCDD, 32'h11223344, 4'b1111, 32'hDDCCBBAA, 32'h44332211, 4'b0000, 1'b1}, // R7
        '{2'd2, 2'd2, 1'b1, 32'hAABBCCDD, 32'h11223344, 4'b1111, 32'hDDCCBBAA, 32'h44332211, 4'b0000, 1'b1}, // R7
        '{2'd3, 2'd0, 1'b0, 32'hAABBCCDD, 32'h11223344, 4'b1111, 32'hDDCCBBAA, 32'h44332211, 4'b0000, 1'b1}  // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected outputs from the requirements (R1..R8).
    task automatic model(input logic [1:0] sz, input logic [1:0] ad, input logic rv,
                         input logic [31:0] rd, input logic [31:0] wd, input logic [3:0] be,
                         output logic [31:0] xrd, output logic [31:0] xwd,
                         output logic [3:0] xbe, output logic xer);
        int mask;
        int m;
        mask = (1 << sz) - 1;
        xer  = (sz > 2) || ((int'(ad) & mask) != 0);
        m    = (rv && !xer) ? (mask & 3) : 0;
        for (int j = 0; j < 4; j++) begin
            xrd[31-8*j -: 8]  = rd[8*(j ^ m) +: 8];
            xwd[8*j +: 8]     = wd[31-8*(j ^ m) -: 8];
            xbe[j]            = xer ? 1'b0 : be[3-(j ^ m)];
        end
    endtask

    task automatic apply(input string tag, input logic [1:0] sz, input logic [1:0] ad,
                         input logic rv, input logic [31:0] rd, input logic [31:0] wd,
                         input logic [3:0] be, input logic [31:0] xrd, input logic [31:0] xwd,
                         input logic [3:0] xbe, input logic xer);
        @(negedge clk);
        acc_size = sz; acc_addr = ad; rev_en = rv;
        bus_rdata = rd; cpu_wdata = wd; cpu_ben = be;
        #1;
        chk({tag, " rdata"}, c_rdata, xrd);
        chk({tag, " wdata"}, c_wdata, xwd);
        chk({tag, " ben"}, {28'd0, c_ben}, {28'd0, xbe});
        chk({tag, " err"}, {31'd0, c_err}, {31'd0, xer});
        // R9: registered copy still holds the previous result before the edge
        chk("R9 hold rdata", r_rdata, p_rd);
        chk("R9 hold ben", {27'd0, r_ben, r_err}, {27'd0, p_be, p_er});
        @(posedge clk);
        #1;
        chk("R9 late rdata", r_rdata, xrd);
        chk("R9 late wdata", r_wdata, xwd);
        chk("R9 late ben", {27'd0, r_ben, r_err}, {27'd0, xbe, xer});
        p_rd = xrd; p_wd = xwd; p_be = xbe; p_er = xer;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R9 act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] xrd, xwd, lfsr;
        logic [3:0]  xbe;
        logic        xer;

        // R9: reset clears the registered outputs while inputs are live
        acc_size = 2'd2; rev_en = 1'b1; bus_rdata = 32'h12345678;
        cpu_wdata = 32'h9ABCDEF0; cpu_ben = 4'b1111;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset rdata", r_rdata, 32'd0);
        chk("R9 reset wdata", r_wdata, 32'd0);
        chk("R9 reset ben", {27'd0, r_ben, r_err}, 32'd0);
        chk("R5 comb during reset", c_rdata, 32'h12345678);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        p_rd = r_rdata; p_wd = r_wdata; p_be = r_ben; p_er = r_err;

        // Table walk
        foreach (VECS[i]) begin
            apply($sformatf("R1-table %0d", i), VECS[i].sz, VECS[i].ad, VECS[i].rv,
                  VECS[i].rd, VECS[i].wd, VECS[i].be,
                  VECS[i].xrd, VECS[i].xwd, VECS[i].xbe, VECS[i].xer);
        end

        // R1: single-bit positions inside a lane
        apply("R1 bit7->bit0", 2'd2, 2'd0, 1'b0, 32'h00000080, 32'h0, 4'b0000,
              32'h80000000, 32'h0, 4'b0000, 1'b0);
        apply("R1 bit24->bit31", 2'd2, 2'd0, 1'b0, 32'h01000000, 32'h0, 4'b0000,
              32'h00000001, 32'h0, 4'b0000, 1'b0);
        // R2: big-endian bit 0 lands on peripheral bit 7
        apply("R2 bit0->bit7", 2'd2, 2'd0, 1'b0, 32'h0, 32'h80000000, 4'b1000,
              32'h0, 32'h00000080, 4'b0001, 1'b0);

        // Exhaustive size/address/enable sweep with changing data (R3..R8)
        lfsr = 32'hACE1_1234;
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
                for (int r = 0; r < 2; r++) begin
                    logic [31:0] rd, wd;
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    rd = lfsr;
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    wd = lfsr;
                    model(2'(s), 2'(a), 1'(r), rd, wd, lfsr[7:4], xrd, xwd, xbe, xer);
                    apply("R6 sweep", 2'(s), 2'(a), 1'(r), rd, wd, lfsr[7:4],
                          xrd, xwd, xbe, xer);
                end
            end
        end

        // R9: reset in the middle of traffic clears the register again
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 mid reset", {r_rdata ^ r_wdata}, 32'd0);
        chk("R9 mid reset ben", {27'd0, r_ben, r_err}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule